// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture channel that hangs off a free-running up-counter. An asynchronous pin passes through a two-flop synchronizer and then a programmable digital glitch filter. The filter takes its samples on a sampling strobe. A polarity bit selects which edge of the filtered level is the active one. An event prescaler can then thin the stream of active edges.

On each accepted event, the current counter value is latched into the capture register. The same event sets a capture flag and can raise an interrupt request and a one-cycle DMA request.

Software reaches the channel through a small word-addressed register port with three registers:

- Control (address 0) sets the channel mode, filter code, polarity, prescaler and the three enables.
- Status (address 1) holds the capture and overcapture flags. Software clears a flag by writing 0 to its bit.
- Capture (address 2) returns the latched counter value. Software can write it only while the channel is in output mode.

Top module: `icap_channel`

## Requirements
- R1: After reset, the control, status and capture registers read 0, and `irq_o` and `dma_o` are low.
- R2: With the mode field (control bits 1:0) at 00, the channel never captures, and a write to the capture register (address 2) stores the written value.
- R3: With a non-zero mode field, writes to the capture register are ignored and the channel captures from its own pin.
- R4: Filter code (control bits 5:2) 0000 passes each synchronized level change straight through. Code c from 1 to 3 needs 2^c consecutive samples of the new level. Code c from 4 to 15 needs 4*c consecutive samples. A shorter excursion is discarded.
- R5: The filter counts a sample only in a cycle where `sample_en` is high.
- R6: Polarity (control bit 6) set to 0 makes the rising edge of the filtered level active. Set to 1, the falling edge is active.
- R7: Prescaler (control bits 8:7) values 00, 01, 10 and 11 capture on every 1st, 2nd, 4th and 8th active edge.
- R8: The prescaler edge count restarts from zero when capture enable is cleared or when the prescaler field is written with a different value.
- R9: A capture copies `cnt_i` into the capture register, and happens only while capture enable (control bit 9) is set.
- R10: A capture sets status bit 0. A capture while bit 0 is already set also sets overcapture bit 1. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.
- R11: `irq_o` equals status bit 0 ANDed with interrupt enable (control bit 10). `dma_o` pulses for one cycle, in the cycle after a capture, when DMA enable (control bit 11) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CW | Free-running counter value |
| sample_en | input | 1 | Filter sampling strobe |
| pin_i | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 capture |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request level |
| dma_o | output | 1 | One-cycle DMA request |

## Verification
The assertions check on every cycle that:

- a capture never happens with capture enable low or with the channel in output mode;
- the capture register holds still under software writes in input mode;
- each capture sets the flag, and sets overcapture when the flag was already set;
- the request outputs follow the flag and the capture event;
- the filtered level holds while the synchronized input agrees with it.

Only the bench scenarios can show the rest. These are the filter's exact sample counts and how the sampling strobe stretches them, the choice of edge made by polarity, the prescaler ratios and the restart of the prescaler count, and the counter value that is captured.

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CW  = 16,
  parameter int FCW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          sample_en,
  input  logic          pin_i,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          dma_o
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CAP = 2'd2;

  logic [1:0] mode_q, psc_q;
  logic [3:0] fcode_q;
  logic pol_q, cen_q, ien_q, den_q;
  logic [1:0] sync_q;
  logic filt_q, filt_d_q;
  logic [FCW-1:0] fcnt_q;
  logic [2:0] pcnt_q;
  logic [CW-1:0] cap_q;
  logic ccf_q, ovf_q, dma_q;

  function automatic logic [FCW-1:0] flen(input logic [3:0] c);
    if (c < 4'd4) flen = FCW'(1) << c;
    else          flen = FCW'(c) * FCW'(4);
  endfunction

  wire sync_lvl = sync_q[1];
  wire ctrl_wr  = reg_wr && reg_addr == A_CTRL;
  wire stat_wr  = reg_wr && reg_addr == A_STAT;
  wire cap_wr   = reg_wr && reg_addr == A_CAP;
  wire psc_chg  = ctrl_wr && reg_wdata[8:7] != psc_q;
  wire active   = (filt_q != filt_d_q) && (filt_q == ~pol_q);
  wire valid    = active && mode_q != 2'b00 && cen_q;
  wire [2:0] div_m1 = 3'((4'd1 << psc_q) - 4'd1);
  wire capture  = valid && pcnt_q == div_m1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {den_q, ien_q, cen_q, psc_q, pol_q, fcode_q, mode_q} <= '0;
    end else if (ctrl_wr) begin
      {den_q, ien_q, cen_q, psc_q, pol_q, fcode_q, mode_q} <= reg_wdata[11:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q   <= '0;
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
      fcnt_q   <= '0;
    end else begin
      sync_q   <= {sync_q[0], pin_i};
      filt_d_q <= filt_q;
      if (fcode_q == 4'd0) begin
        filt_q <= sync_lvl;
        fcnt_q <= '0;
      end else if (sync_lvl == filt_q) begin
        fcnt_q <= '0;
      end else if (sample_en) begin
        if (fcnt_q + FCW'(1) >= flen(fcode_q)) begin
          filt_q <= sync_lvl;
          fcnt_q <= '0;
        end else begin
          fcnt_q <= fcnt_q + FCW'(1);
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pcnt_q <= '0;
    else if (!cen_q || psc_chg) pcnt_q <= '0;
    else if (valid)            pcnt_q <= capture ? 3'd0 : pcnt_q + 3'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             cap_q <= '0;
    else if (capture)                       cap_q <= cnt_i;
    else if (cap_wr && mode_q == 2'b00)     cap_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ccf_q <= 1'b0;
      ovf_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      dma_q <= capture && den_q;
      if (stat_wr) begin
        ccf_q <= ccf_q & reg_wdata[0];
        ovf_q <= ovf_q & reg_wdata[1];
      end
      if (capture) begin
        ccf_q <= 1'b1;
        if (ccf_q) ovf_q <= 1'b1;
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[11:0] = {den_q, ien_q, cen_q, psc_q, pol_q, fcode_q, mode_q};
      A_STAT:  reg_rdata[1:0]  = {ovf_q, ccf_q};
      A_CAP:   reg_rdata       = cap_q;
      default: reg_rdata       = '0;
    endcase
  end

  assign irq_o = ccf_q && ien_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          capture,
  input logic          cen,
  input logic          ien,
  input logic          den,
  input logic [1:0]    mode,
  input logic [3:0]    fcode,
  input logic          sync_lvl,
  input logic          filt,
  input logic [CW-1:0] cap,
  input logic          ccf,
  input logic          ovf,
  input logic          irq_o,
  input logic          dma_o
);
  AST_CAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> cen); // R9
  AST_NO_CAP_OUTMODE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> mode != 2'b00); // R2
  AST_RO_IN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && !capture) |=> $stable(cap)); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ccf); // R10
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && ccf) |=> ovf); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ccf && ien)); // R11
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && den) |=> dma_o); // R11
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_o) |-> $past(capture)); // R11
  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fcode != 4'd0 && sync_lvl == filt) |=> $stable(filt)); // R4
endmodule

bind icap_channel icap_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .capture(capture), .cen(cen_q), .ien(ien_q),
  .den(den_q), .mode(mode_q), .fcode(fcode_q), .sync_lvl(sync_lvl),
  .filt(filt_q), .cap(cap_q), .ccf(ccf_q), .ovf(ovf_q),
  .irq_o(irq_o), .dma_o(dma_o)
);

// File: tb/tb_icap_channel.sv
`timescale 1ns/1ps
module tb_icap_channel;
  logic clk = 0, rst_n = 0;
  logic [15:0] cnt_i = '0, reg_wdata = '0;
  logic sample_en = 1, pin_i = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_rdata;
  logic irq_o, dma_o;
  int total = 0, bad = 0, ndma = 0;
  bit done = 0;

  icap_channel dut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) if (dma_o) ndma++;

  function automatic int flen(int c);
    return (c == 0) ? 1 : (c < 4) ? (1 << c) : 4 * c;
  endfunction
  function automatic int pdiv(int p);
    return 1 << p;
  endfunction
  function automatic logic [15:0] mkctrl(int mode, int f, int pol, int psc,
                                         int ce, int ie, int de);
    return 16'({de[0], ie[0], ce[0], psc[1:0], pol[0], f[3:0], mode[1:0]});
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(int w, int gap);
    @(negedge clk); pin_i = 1;
    repeat (w) @(negedge clk);
    pin_i = 0;
    repeat (gap) @(negedge clk);
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    rd(2, v); chk("R1 capture", v, 0);
    chk("R1 irq/dma", {irq_o, dma_o}, 0);

    wr(2, 16'h1234);
    rd(2, v); chk("R2 write in output mode", v, 16'h1234);
    wr(0, mkctrl(0, 0, 0, 0, 1, 0, 1));
    pulse(20, 30);
    rd(1, v); chk("R2 no capture in output mode", v, 0);

    wr(0, mkctrl(1, 0, 0, 0, 0, 0, 1));
    wr(2, 16'h5555);
    rd(2, v); chk("R3 capture read-only", v, 16'h1234);
    pulse(20, 30);
    rd(1, v); chk("R9 no capture when disabled", v, 0);

    wr(0, mkctrl(1, 0, 0, 0, 1, 1, 1));
    cnt_i = 16'hABCD;
    pulse(20, 30);
    rd(2, v); chk("R9 value latched", v, 16'hABCD);
    rd(1, v); chk("R10 flag set", v, 1);
    chk("R11 irq on flag", irq_o, 1);
    chk("R11 one dma pulse", ndma, 1);
    pulse(20, 30);
    rd(1, v); chk("R10 overcapture", v, 3);
    wr(1, 16'h0002);
    rd(1, v); chk("R10 clear flag keeps ovf", v, 2);
    chk("R11 irq drops", irq_o, 0);
    wr(1, 16'h0000);

    wr(0, mkctrl(1, 3, 0, 0, 1, 0, 1));
    ndma = 0;
    pulse(7, 40);
    chk("R4 7-sample glitch rejected", ndma, 0);
    pulse(8, 40);
    chk("R4 8-sample level accepted", ndma, 1);

    wr(0, mkctrl(1, 0, 1, 0, 1, 0, 1));
    cnt_i = 16'h1111;
    @(negedge clk); pin_i = 1;
    repeat (20) @(negedge clk);
    pin_i = 0; cnt_i = 16'h2222;
    repeat (30) @(negedge clk);
    rd(2, v); chk("R6 falling edge captures", v, 16'h2222);
    wr(0, mkctrl(1, 0, 0, 0, 1, 0, 1));
    cnt_i = 16'h3333;
    @(negedge clk); pin_i = 1;
    repeat (20) @(negedge clk);
    pin_i = 0; cnt_i = 16'h4444;
    repeat (30) @(negedge clk);
    rd(2, v); chk("R6 rising edge captures", v, 16'h3333);

    wr(0, mkctrl(1, 2, 0, 0, 1, 0, 1));
    ndma = 0;
    fork
      begin
        repeat (120) begin
          @(negedge clk); sample_en = 0;
          repeat (3) @(negedge clk);
          sample_en = 1;
        end
      end
      begin
        pulse(8, 40);
        chk("R5 sparse strobe rejects 8 cycles", ndma, 0);
        pulse(40, 40);
        chk("R5 sparse strobe accepts 40 cycles", ndma, 1);
      end
    join
    sample_en = 1;

    wr(0, mkctrl(1, 0, 0, 2, 1, 0, 1));
    ndma = 0;
    repeat (3) pulse(10, 20);
    wr(0, mkctrl(1, 0, 0, 2, 0, 0, 1));
    wr(0, mkctrl(1, 0, 0, 2, 1, 0, 1));
    repeat (3) pulse(10, 20);
    chk("R8 disable restarts count", ndma, 0);
    pulse(10, 20);
    chk("R8 4th edge after restart", ndma, 1);
    ndma = 0;
    repeat (3) pulse(10, 20);
    wr(0, mkctrl(1, 0, 0, 1, 1, 0, 1));
    pulse(10, 20);
    chk("R8 psc change restarts count", ndma, 0);
    pulse(10, 20);
    chk("R8 2nd edge after change", ndma, 1);

    begin
      void'($urandom(32'd2024));
      for (int r = 0; r < 24; r++) begin
        int f, pol, psc, n, d;
        logic [15:0] expv, cur;
        f = $urandom_range(0, 4); pol = $urandom_range(0, 1);
        psc = $urandom_range(0, 3); n = $urandom_range(1, 12);
        d = pdiv(psc);
        wr(0, 16'h0000);
        wr(1, 16'h0000);
        wr(2, 16'h0000);
        expv = 16'h0000;
        wr(0, mkctrl(1, f, pol, psc, 1, 0, 1));
        ndma = 0;
        for (int k = 0; k < n; k++) begin
          cur = 16'($urandom);
          cnt_i = cur;
          if ((k + 1) % d == 0) expv = cur;
          pulse(flen(f) + $urandom_range(0, 10), flen(f) + 30);
        end
        chk("R7 capture count", ndma, n / d);
        rd(2, v); chk("R9 random capture value", v, expv);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule